// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the serial test port of a chip. It contains the sixteen-state test controller, which TMS steers on the rising edge of TCK. It also holds a 4-bit instruction register with its decoder, a one-bit bypass path, a 32-bit identification register and a boundary register of `NI + NO` cells. The boundary register sits between the core and its pads. Each cell has a shift stage, which is captured and shifted on the rising edge of TCK, and an update stage, which is loaded on the falling edge.

The active instruction does two things. It chooses which data register lies between TDI and TDO. It also sets the multiplexers next to the pads. The pads can pass functional values through, take their output values from the update stage, feed the core from the update stage, or turn all pad drivers off. A board tester uses the port to check interconnect, to test the core on its own, to take snapshots of live pin values, and to park the pads in a known or floating state.

Top module: `jtag_tap_bscan`

## Requirements
- R1: The controller follows the standard sixteen-state graph. It advances only on a rising TCK edge, on the sampled TMS value. Five consecutive rising edges with TMS high reach Test-Logic-Reset from any state. In that state the IDCODE instruction is loaded on the falling edge.
- R2: With `trst` high and no clock edge needed, the block enters Test-Logic-Reset, holds the IDCODE instruction, clears the update stage and drives `tdo` and `tdo_en` low.
- R3: The instruction is 4 bits wide and is shifted in least significant bit first. Capture-IR loads 0001, so the first bit out is 1. The new instruction takes effect on the falling edge in Update-IR. The codes are: 0000 external test, 0001 IDCODE, 0100 high-impedance, 0101 sample/preload, 0110 internal test, 0111 clamp and 1111 bypass. Every other code behaves as bypass.
- R4: Under IDCODE, the 32-bit identification register captures `ID_VALUE` with bit 0 forced to 1 and shifts it out starting from bit 0.
- R5: Under bypass, the one-bit register captures 0. The serial output is therefore 0 first, then TDI delayed by one shift.
- R6: External test, sample/preload and internal test select the boundary register. In Capture-DR, cells 0 to NI-1 load `pad_in` and cells NI to NI+NO-1 load `core_out`. Shifting moves toward TDO from cell 0, and TDI enters the top cell.
- R7: The update stage copies the shift stage only on the falling edge in Update-DR, and only while the boundary register is selected. It holds its value through capture, shift and pause.
- R8: Under IDCODE, bypass, sample/preload and undefined codes, `pad_out` equals `core_out`, `core_in` equals `pad_in` and `pad_oe` is all ones.
- R9: Under external test, `pad_out` takes update-stage cells NI to NI+NO-1 and `core_in` still follows `pad_in`.
- R10: Under internal test, `core_in` takes update-stage cells 0 to NI-1 and `pad_out` takes the output cells of the update stage.
- R11: Clamp drives `pad_out` from the output cells of the update stage with the pads enabled. High-impedance sets every `pad_oe` bit to 0. Both select the bypass register.
- R12: `tdo` and `tdo_en` change only on a falling TCK edge. `tdo_en` is 1 exactly while the controller is in Shift-DR or Shift-IR. Outside those states `tdo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst | input | 1 | Asynchronous test reset, active high |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, changes on falling TCK |
| tdo_en | output | 1 | Driver enable for `tdo` |
| pad_in | input | NI | Values arriving from input pads |
| core_out | input | NO | Functional outputs of the core |
| core_in | output | NI | Values delivered to the core inputs |
| pad_out | output | NO | Values sent to output pads |
| pad_oe | output | NO | Output pad drive enables, 1 = drive |

## Verification
Two events can fall in the same cycle. The first is the update stage loading on the falling edge of Update-DR while the active instruction routes that stage straight to the pads. The bench shifts a new pattern under external test and checks that `pad_out` still shows the old pattern after the last shift. It then checks that `pad_out` shows the new pattern immediately after the Update-DR falling edge. The second is an asynchronous reset that lands in the middle of a shift while `tdo_en` is high. The bench checks that the serial output is released at once, without a clock edge, and that the identification code is the register read first after the reset. A behavioural model runs in lockstep and judges every pad and serial output on every clock.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

    localparam int IR_W = 4;
    localparam int ID_W = 32;
    localparam logic [IR_W-1:0] IR_CAPTURE = {{(IR_W-1){1'b0}}, 1'b1};

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [IR_W-1:0] {
        OP_EXTEST = 4'b0000,
        OP_IDCODE = 4'b0001,
        OP_HIGHZ  = 4'b0100,
        OP_SAMPLE = 4'b0101,
        OP_INTEST = 4'b0110,
        OP_CLAMP  = 4'b0111,
        OP_BYPASS = 4'b1111
    } tap_op_e;

    typedef enum logic [1:0] {
        DR_BYP = 2'd0,
        DR_ID  = 2'd1,
        DR_BSR = 2'd2
    } dr_sel_e;

    typedef struct packed {
        dr_sel_e dr;
        logic    pad_drv_upd;
        logic    core_drv_upd;
        logic    pads_hiz;
    } tap_mode_t;

    function automatic tap_state_e tap_next(tap_state_e s, logic tms);
        tap_state_e n;
        case (s)
            ST_TLR:    n = tms ? ST_TLR    : ST_RTI;
            ST_RTI:    n = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: n = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: n = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  n = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: n = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: n = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: n = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: n = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: n = tms ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: n = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  n = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: n = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: n = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: n = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: n = tms ? ST_SEL_DR : ST_RTI;
            default:   n = ST_TLR;
        endcase
        return n;
    endfunction

    function automatic tap_mode_t tap_decode(logic [IR_W-1:0] op);
        tap_mode_t m;
        m.dr           = DR_BYP;
        m.pad_drv_upd  = 1'b0;
        m.core_drv_upd = 1'b0;
        m.pads_hiz     = 1'b0;
        case (op)
            OP_EXTEST: begin
                m.dr          = DR_BSR;
                m.pad_drv_upd = 1'b1;
            end
            OP_IDCODE: m.dr = DR_ID;
            OP_HIGHZ:  m.pads_hiz = 1'b1;
            OP_SAMPLE: m.dr = DR_BSR;
            OP_INTEST: begin
                m.dr           = DR_BSR;
                m.pad_drv_upd  = 1'b1;
                m.core_drv_upd = 1'b1;
            end
            OP_CLAMP:  m.pad_drv_upd = 1'b1;
            default:   m.dr = DR_BYP;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import jtag_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst,
    input  logic       tms,
    output tap_state_e st
);

    always_ff @(posedge tck or posedge trst) begin
        if (trst) begin
            st <= ST_TLR;
        end else begin
            st <= tap_next(st, tms);
        end
    end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import jtag_tap_pkg::*;
(
    input  logic            tck,
    input  logic            trst,
    input  tap_state_e      st,
    input  logic            tdi,
    output logic            so,
    output logic [IR_W-1:0] ir_q,
    output tap_mode_t       mode
);

    logic [IR_W-1:0] sr_q;

    // Shift stage: capture and shift on rising TCK
    always_ff @(posedge tck or posedge trst) begin
        if (trst) begin
            sr_q <= '0;
        end else if (st == ST_CAP_IR) begin
            sr_q <= IR_CAPTURE;
        end else if (st == ST_SH_IR) begin
            sr_q <= {tdi, sr_q[IR_W-1:1]};
        end
    end

    // Active instruction: changes on falling TCK only
    always_ff @(negedge tck or posedge trst) begin
        if (trst) begin
            ir_q <= OP_IDCODE;
        end else if (st == ST_TLR) begin
            ir_q <= OP_IDCODE;
        end else if (st == ST_UPD_IR) begin
            ir_q <= sr_q;
        end
    end

    assign so   = sr_q[0];
    assign mode = tap_decode(ir_q);

endmodule

// File: rtl/tap_bsr.sv
module tap_bsr
    import jtag_tap_pkg::*;
#(
    parameter int NI = 4,
    parameter int NO = 4
) (
    input  logic            tck,
    input  logic            trst,
    input  tap_state_e      st,
    input  logic            tdi,
    input  logic            sel,
    input  logic            pad_drv_upd,
    input  logic            core_drv_upd,
    input  logic            pads_hiz,
    input  logic [NI-1:0]   pad_in,
    input  logic [NO-1:0]   core_out,
    output logic [NI-1:0]   core_in,
    output logic [NO-1:0]   pad_out,
    output logic [NO-1:0]   pad_oe,
    output logic            so,
    output logic [NI+NO-1:0] upd_q
);

    localparam int L = NI + NO;

    logic [L-1:0] sr_q;

    always_ff @(posedge tck or posedge trst) begin
        if (trst) begin
            sr_q <= '0;
        end else if (sel && st == ST_CAP_DR) begin
            sr_q <= {core_out, pad_in};
        end else if (sel && st == ST_SH_DR) begin
            sr_q <= {tdi, sr_q[L-1:1]};
        end
    end

    always_ff @(negedge tck or posedge trst) begin
        if (trst) begin
            upd_q <= '0;
        end else if (sel && st == ST_UPD_DR) begin
            upd_q <= sr_q;
        end
    end

    assign so = sr_q[0];

    // Input cells: pad toward core
    for (genvar gi = 0; gi < NI; gi++) begin : g_in_cell
        assign core_in[gi] = core_drv_upd ? upd_q[gi] : pad_in[gi];
    end

    // Output cells: core toward pad
    for (genvar go = 0; go < NO; go++) begin : g_out_cell
        assign pad_out[go] = pad_drv_upd ? upd_q[NI+go] : core_out[go];
        assign pad_oe[go]  = ~pads_hiz;
    end

endmodule

// File: rtl/jtag_tap_bscan.sv
module jtag_tap_bscan
    import jtag_tap_pkg::*;
#(
    parameter int          NI       = 4,
    parameter int          NO       = 4,
    parameter logic [31:0] ID_VALUE = 32'h4B1D_70C5
) (
    input  logic          tck,
    input  logic          trst,
    input  logic          tms,
    input  logic          tdi,
    output logic          tdo,
    output logic          tdo_en,
    input  logic [NI-1:0] pad_in,
    input  logic [NO-1:0] core_out,
    output logic [NI-1:0] core_in,
    output logic [NO-1:0] pad_out,
    output logic [NO-1:0] pad_oe
);

    localparam int L = NI + NO;
    localparam logic [ID_W-1:0] ID_CAPTURE = ID_VALUE | {{(ID_W-1){1'b0}}, 1'b1};

    tap_state_e      st;
    logic [IR_W-1:0] ir_q;
    tap_mode_t       mode;
    logic            ir_so;
    logic            bsr_so;
    logic [L-1:0]    bsr_upd;
    logic            byp_q;
    logic [ID_W-1:0] id_sr;
    logic            dr_so;

    tap_fsm u_fsm (
        .tck (tck),
        .trst(trst),
        .tms (tms),
        .st  (st)
    );

    tap_ir u_ir (
        .tck (tck),
        .trst(trst),
        .st  (st),
        .tdi (tdi),
        .so  (ir_so),
        .ir_q(ir_q),
        .mode(mode)
    );

    tap_bsr #(.NI(NI), .NO(NO)) u_bsr (
        .tck         (tck),
        .trst        (trst),
        .st          (st),
        .tdi         (tdi),
        .sel         (mode.dr == DR_BSR),
        .pad_drv_upd (mode.pad_drv_upd),
        .core_drv_upd(mode.core_drv_upd),
        .pads_hiz    (mode.pads_hiz),
        .pad_in      (pad_in),
        .core_out    (core_out),
        .core_in     (core_in),
        .pad_out     (pad_out),
        .pad_oe      (pad_oe),
        .so          (bsr_so),
        .upd_q       (bsr_upd)
    );

    // Bypass cell
    always_ff @(posedge tck or posedge trst) begin
        if (trst) begin
            byp_q <= 1'b0;
        end else if (mode.dr == DR_BYP && st == ST_CAP_DR) begin
            byp_q <= 1'b0;
        end else if (mode.dr == DR_BYP && st == ST_SH_DR) begin
            byp_q <= tdi;
        end
    end

    // Identification register
    always_ff @(posedge tck or posedge trst) begin
        if (trst) begin
            id_sr <= '0;
        end else if (mode.dr == DR_ID && st == ST_CAP_DR) begin
            id_sr <= ID_CAPTURE;
        end else if (mode.dr == DR_ID && st == ST_SH_DR) begin
            id_sr <= {tdi, id_sr[ID_W-1:1]};
        end
    end

    always_comb begin
        case (mode.dr)
            DR_ID:   dr_so = id_sr[0];
            DR_BSR:  dr_so = bsr_so;
            default: dr_so = byp_q;
        endcase
    end

    // Serial output retimed to falling TCK
    always_ff @(negedge tck or posedge trst) begin
        if (trst) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo_en <= (st == ST_SH_DR) || (st == ST_SH_IR);
            if (st == ST_SH_IR) begin
                tdo <= ir_so;
            end else if (st == ST_SH_DR) begin
                tdo <= dr_so;
            end else begin
                tdo <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/tap_chk.sv
module tap_chk
    import jtag_tap_pkg::*;
#(
    parameter int NI = 4,
    parameter int NO = 4
) (
    input logic            tck,
    input logic            trst,
    input logic            tms,
    input logic            tdo_en,
    input tap_state_e      st,
    input logic [IR_W-1:0] ir_q,
    input logic [NI-1:0]   pad_in,
    input logic [NO-1:0]   core_out,
    input logic [NI-1:0]   core_in,
    input logic [NO-1:0]   pad_out,
    input logic [NO-1:0]   pad_oe,
    input logic [NI+NO-1:0] upd
);

    p_tlr_reach_r1: assert property (@(posedge tck) disable iff (trst)
        (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4)) |=> st == ST_TLR);

    p_ir_hold_r3: assert property (@(posedge tck) disable iff (trst)
        (st != ST_UPD_IR && st != ST_TLR) |-> $stable(ir_q));

    p_upd_hold_r7: assert property (@(posedge tck) disable iff (trst)
        (st != ST_UPD_DR) |-> $stable(upd));

    p_sample_transparent_r8: assert property (@(posedge tck) disable iff (trst)
        (ir_q == OP_SAMPLE) |-> (pad_out == core_out && core_in == pad_in && pad_oe == '1));

    p_extest_drive_r9: assert property (@(posedge tck) disable iff (trst)
        (ir_q == OP_EXTEST) |-> (pad_out == upd[NI+NO-1:NI] && core_in == pad_in));

    p_intest_core_r10: assert property (@(posedge tck) disable iff (trst)
        (ir_q == OP_INTEST) |-> (core_in == upd[NI-1:0]));

    p_highz_off_r11: assert property (@(posedge tck) disable iff (trst)
        (ir_q == OP_HIGHZ) |-> (pad_oe == '0));

    p_clamp_drive_r11: assert property (@(posedge tck) disable iff (trst)
        (ir_q == OP_CLAMP) |-> (pad_out == upd[NI+NO-1:NI] && pad_oe == '1));

    p_tdo_en_window_r12: assert property (@(posedge tck) disable iff (trst)
        tdo_en == (st == ST_SH_DR || st == ST_SH_IR));

endmodule

bind jtag_tap_bscan tap_chk #(.NI(NI), .NO(NO)) u_chk (
    .tck     (tck),
    .trst    (trst),
    .tms     (tms),
    .tdo_en  (tdo_en),
    .st      (st),
    .ir_q    (ir_q),
    .pad_in  (pad_in),
    .core_out(core_out),
    .core_in (core_in),
    .pad_out (pad_out),
    .pad_oe  (pad_oe),
    .upd     (bsr_upd)
);

// File: tb/tb_jtag_tap_bscan.sv
`timescale 1ns/1ps
module tb_jtag_tap_bscan;

    localparam int          NI   = 4;
    localparam int          NO   = 4;
    localparam int          L    = NI + NO;
    localparam logic [31:0] ID_V = 32'h4B1D_70C5;

    // Model state numbering (bench-own)
    localparam int S_TLR = 0,  S_RTI = 1,  S_SDR = 2,  S_CDR = 3,  S_SHD = 4,  S_E1D = 5;
    localparam int S_PD  = 6,  S_E2D = 7,  S_UDR = 8,  S_SIR = 9,  S_CIR = 10, S_SHI = 11;
    localparam int S_E1I = 12, S_PI  = 13, S_E2I = 14, S_UIR = 15;

    logic          tck = 1'b0;
    logic          trst, tms, tdi;
    logic          tdo, tdo_en;
    logic [NI-1:0] pad_in;
    logic [NO-1:0] core_out;
    logic [NI-1:0] core_in;
    logic [NO-1:0] pad_out;
    logic [NO-1:0] pad_oe;

    int cnt  = 0;
    int errs = 0;

    // Reference model state
    int         m_st;
    logic [3:0] m_ir;
    logic [L-1:0] m_upd;
    logic       m_tdo, m_en;
    bit         dq[$];
    bit         iq[$];

    jtag_tap_bscan #(.NI(NI), .NO(NO), .ID_VALUE(ID_V)) dut (
        .tck(tck), .trst(trst), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
        .pad_in(pad_in), .core_out(core_out), .core_in(core_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    always #2 tck = ~tck;

    initial begin
        repeat (100000) @(posedge tck);
        errs++;
        $display("FAIL R1 watchdog: actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", cnt, errs);
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        cnt++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int nxt(int s, logic t);
        case (s)
            S_TLR: return t ? S_TLR : S_RTI;
            S_RTI: return t ? S_SDR : S_RTI;
            S_SDR: return t ? S_SIR : S_CDR;
            S_CDR: return t ? S_E1D : S_SHD;
            S_SHD: return t ? S_E1D : S_SHD;
            S_E1D: return t ? S_UDR : S_PD;
            S_PD:  return t ? S_E2D : S_PD;
            S_E2D: return t ? S_UDR : S_SHD;
            S_UDR: return t ? S_SDR : S_RTI;
            S_SIR: return t ? S_TLR : S_CIR;
            S_CIR: return t ? S_E1I : S_SHI;
            S_SHI: return t ? S_E1I : S_SHI;
            S_E1I: return t ? S_UIR : S_PI;
            S_PI:  return t ? S_E2I : S_PI;
            S_E2I: return t ? S_UIR : S_SHI;
            default: return t ? S_SDR : S_RTI;
        endcase
    endfunction

    // 0 bypass, 1 id, 2 boundary
    function automatic int msel(logic [3:0] ir);
        if (ir == 4'b0001) return 1;
        if (ir == 4'b0000 || ir == 4'b0101 || ir == 4'b0110) return 2;
        return 0;
    endfunction

    task automatic model_reset();
        m_st = S_TLR; m_ir = 4'b0001; m_upd = '0; m_tdo = 1'b0; m_en = 1'b0;
        dq.delete(); iq.delete();
    endtask

    task automatic model_rise(input logic t, input logic d);
        if (m_st == S_CDR) begin
            dq.delete();
            case (msel(m_ir))
                1: for (int i = 0; i < 32; i++) dq.push_back(i == 0 ? 1'b1 : ID_V[i]);
                2: begin
                    for (int i = 0; i < NI; i++) dq.push_back(pad_in[i]);
                    for (int i = 0; i < NO; i++) dq.push_back(core_out[i]);
                end
                default: dq.push_back(1'b0);
            endcase
        end else if (m_st == S_SHD) begin
            dq.push_back(d);
            void'(dq.pop_front());
        end else if (m_st == S_CIR) begin
            iq.delete();
            iq.push_back(1'b1);
            for (int i = 1; i < 4; i++) iq.push_back(1'b0);
        end else if (m_st == S_SHI) begin
            iq.push_back(d);
            void'(iq.pop_front());
        end
        m_st = nxt(m_st, t);
    endtask

    task automatic model_fall();
        if (m_st == S_UDR && msel(m_ir) == 2)
            for (int i = 0; i < L; i++) m_upd[i] = dq[i];
        if (m_st == S_UIR)
            for (int i = 0; i < 4; i++) m_ir[i] = iq[i];
        if (m_st == S_TLR) m_ir = 4'b0001;
        if (m_st == S_SHD)      begin m_tdo = dq[0]; m_en = 1'b1; end
        else if (m_st == S_SHI) begin m_tdo = iq[0]; m_en = 1'b1; end
        else                    begin m_tdo = 1'b0;  m_en = 1'b0; end
    endtask

    task automatic compare();
        logic [NO-1:0] e_oe, e_po;
        logic [NI-1:0] e_ci;
        e_oe = (m_ir == 4'b0100) ? '0 : '1;
        e_po = (m_ir == 4'b0000 || m_ir == 4'b0110 || m_ir == 4'b0111) ? m_upd[L-1:NI] : core_out;
        e_ci = (m_ir == 4'b0110) ? m_upd[NI-1:0] : pad_in;
        chk(tdo === m_tdo, "R12 tdo", 64'(tdo), 64'(m_tdo));
        chk(tdo_en === m_en, "R12 tdo_en", 64'(tdo_en), 64'(m_en));
        chk(pad_oe === e_oe, "R11 pad_oe", 64'(pad_oe), 64'(e_oe));
        chk(pad_out === e_po, "R9 pad_out", 64'(pad_out), 64'(e_po));
        chk(core_in === e_ci, "R10 core_in", 64'(core_in), 64'(e_ci));
    endtask

    task automatic step(input logic t, input logic d);
        tms = t; tdi = d;
        @(posedge tck); model_rise(t, d);
        @(negedge tck); model_fall();
        #1; compare();
    endtask

    task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
        dout = '0;
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < n; i++) begin
            dout[i] = tdo;
            step(i == n - 1, din[i]);
        end
        step(1, 0); step(0, 0);
    endtask

    task automatic scan_ir(input logic [3:0] op, output logic [3:0] cap);
        cap = '0;
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 4; i++) begin
            cap[i] = tdo;
            step(i == 3, op[i]);
        end
        step(1, 0); step(0, 0);
    endtask

    task automatic wiggle(input int n);
        for (int i = 0; i < n; i++) begin
            pad_in   = NI'($urandom);
            core_out = NO'($urandom);
            step(0, 0);
        end
    endtask

    initial begin
        logic [63:0] dout;
        logic [3:0]  cap;
        trst = 1'b1; tms = 1'b1; tdi = 1'b0;
        pad_in = 4'h3; core_out = 4'h9;
        model_reset();
        repeat (3) @(negedge tck);
        #1;
        chk(tdo_en == 1'b0 && tdo == 1'b0, "R2 reset tdo", {tdo_en, tdo}, 0);
        chk(pad_oe == '1 && pad_out == core_out && core_in == pad_in, "R8 reset pads",
            {pad_oe, pad_out, core_in}, {4'hF, core_out, pad_in});
        trst = 1'b0;

        step(0, 0);
        chk(tdo_en == 1'b0, "R12 idle tdo_en", 64'(tdo_en), 0);

        // R4: identification after reset
        scan_dr(32, 64'h0, dout);
        chk(dout[31:0] == (ID_V | 32'h1), "R4 idcode", dout[31:0], ID_V | 32'h1);

        // R3 / R5: bypass
        scan_ir(4'b1111, cap);
        chk(cap == 4'b0001, "R3 ir capture", 64'(cap), 64'h1);
        scan_dr(8, 64'hB2, dout);
        chk(dout[7:0] == {8'hB2 << 1}, "R5 bypass delay", dout[7:0], 8'h64);

        // R3: undefined code behaves as bypass
        scan_ir(4'b1010, cap);
        scan_dr(8, 64'h4D, dout);
        chk(dout[7:0] == 8'h9A, "R3 undefined as bypass", dout[7:0], 8'h9A);

        // R6 / R8: sample/preload
        pad_in = 4'hA; core_out = 4'h5;
        scan_ir(4'b0101, cap);
        chk(pad_out == core_out && core_in == pad_in, "R8 sample transparent",
            {pad_out, core_in}, {core_out, pad_in});
        scan_dr(8, 64'h3C, dout);
        chk(dout[7:0] == 8'h5A, "R6 boundary capture", dout[7:0], 8'h5A);
        chk(pad_out == core_out, "R8 sample after update", 64'(pad_out), 64'(core_out));
        wiggle(6);

        // R9: external test drives preloaded value
        pad_in = 4'hA; core_out = 4'h5;
        scan_ir(4'b0000, cap);
        chk(pad_out == 4'h3, "R9 extest pad drive", 64'(pad_out), 64'h3);
        chk(core_in == pad_in, "R9 extest core follows pad", 64'(core_in), 64'(pad_in));

        // R7: update holds through shift, loads on Update-DR falling edge
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 8; i++) begin
            dout[i] = tdo;
            step(i == 7, (8'hC3 >> i) & 1);
        end
        chk(pad_out == 4'h3, "R7 hold before update", 64'(pad_out), 64'h3);
        chk(dout[7:0] == 8'h5A, "R6 extest capture", dout[7:0], 8'h5A);
        step(1, 0);
        chk(pad_out == 4'hC, "R7 update edge", 64'(pad_out), 64'hC);
        step(0, 0);
        wiggle(6);

        // R10: internal test
        scan_ir(4'b0110, cap);
        chk(core_in == 4'h3 && pad_out == 4'hC, "R10 intest drive", {core_in, pad_out}, 8'h3C);
        scan_dr(8, 64'h96, dout);
        chk(core_in == 4'h6 && pad_out == 4'h9, "R10 intest new", {core_in, pad_out}, 8'h69);
        wiggle(6);

        // R11: clamp
        scan_ir(4'b0111, cap);
        chk(pad_out == 4'h9 && pad_oe == '1, "R11 clamp", {pad_oe, pad_out}, 8'hF9);
        scan_dr(4, 64'h5, dout);
        chk(dout[3:0] == 4'hA, "R11 clamp bypass", dout[3:0], 4'hA);

        // R11: high impedance
        scan_ir(4'b0100, cap);
        chk(pad_oe == '0, "R11 highz", 64'(pad_oe), 0);
        scan_dr(4, 64'h3, dout);
        chk(dout[3:0] == 4'h6, "R11 highz bypass", dout[3:0], 4'h6);
        wiggle(4);

        // R1: five TMS-high edges from mid-shift reach reset
        step(1, 0); step(0, 0); step(0, 0); step(0, 1);
        for (int i = 0; i < 5; i++) step(1, 0);
        chk(pad_oe == '1, "R1 tms reset restores pads", 64'(pad_oe), 64'hF);
        step(0, 0);
        scan_dr(32, 64'h0, dout);
        chk(dout[31:0] == (ID_V | 32'h1), "R1 idcode after tms reset", dout[31:0], ID_V | 32'h1);

        // R2: asynchronous reset in the middle of a shift
        scan_ir(4'b0000, cap);
        step(1, 0); step(0, 0); step(0, 0);
        chk(tdo_en == 1'b1, "R12 shift tdo_en", 64'(tdo_en), 1);
        step(0, 1);
        trst = 1'b1;
        #0.5;
        chk(tdo_en == 1'b0 && tdo == 1'b0, "R2 async release", {tdo_en, tdo}, 0);
        chk(pad_out == core_out, "R2 instruction reset", 64'(pad_out), 64'(core_out));
        model_reset();
        repeat (2) @(negedge tck);
        #1;
        trst = 1'b0;
        step(0, 0);
        scan_dr(32, 64'h0, dout);
        chk(dout[31:0] == (ID_V | 32'h1), "R2 idcode after trst", dout[31:0], ID_V | 32'h1);

        $display("  [TB] %0d tests run, %0d failed", cnt, errs);
        $finish;
    end

endmodule